// File: doc/BRIEF.md
# I2C-over-AUX EDID Reply Engine

This block is a register-bus slave that stands in for the control and data registers of a display auxiliary channel. It handles I2C-over-AUX transactions addressed to a display identification (EDID) target. Software first places a request header in the first data register. It then writes the control register with the send-busy bit set. In the same cycle the block classifies the request and updates its target-selection state. It replaces the control word with a completion code and places the reply (acknowledge plus any read byte) into the first data register. No wire-level transfer takes place.

Address-only requests open, reopen or close a transaction, following the middle-of-transaction (MOT) flag. Single-byte reads return the EDID byte at a read pointer. An external EDID store supplies that byte through a combinational index/byte lookup. I2C write payloads are acknowledged and otherwise dropped.

Top module: `aux_edid_responder`

## Requirements
- R1: After synchronous reset the control and all data registers read 0, and the target is neither selected nor available.
- R2: Data registers 1 to 5 sit at offsets 0x14, 0x18, 0x1C, 0x20 and 0x24. A host write stores the value and a read returns it. Any other offset except control (0x10) reads 0, and a write there changes no register.
- R3: A control write with bit 31 (send-busy) clear changes neither the control register, data register 1 nor the target state.
- R4: A control write with bit 31 set replaces the control register with bit 30 (done) set and a reply size in bits 24:20. The size is 2 when header bit 28 (read flag) is 1 and 1 otherwise. All other bits are 0.
- R5: A request of length 3 (control bits 24:20) with header bit 30 (MOT) set and header bits 23:8 equal to 0x0050 selects the target. It records the source port. It marks EDID available exactly when the source port carries a DisplayPort sink.
- R6: A read request of length 4 to a selected, available target returns the EDID byte at the read pointer in data register 1 bits 23:16, with bits 15:0 zero, and advances the pointer by one.
- R7: A read request of length 4 returns 0xFF in bits 23:16 when the target is not selected or not available, and does not move the pointer.
- R8: A read request whose length is neither 3 nor 4 leaves data register 1 unchanged (the control register is still replaced per R4).
- R9: A write request (header bit 28 clear) whose length is not 3 is acknowledged and leaves the read pointer and selection unchanged.
- R10: A length-3 request with MOT clear (stop), or with MOT set and address 0, clears selection, availability and the read pointer.
- R11: The read pointer saturates at 128. A read at the saturated pointer returns 0x00.
- R12: Every request that writes data register 1 puts the acknowledge code 0x00 in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset (low byte) for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_port | input | 3 | Port index the channel belongs to |
| src_dp_sink | input | 1 | The source port carries a DisplayPort sink |
| edid_idx | output | 7 | Index into the EDID store |
| edid_byte | input | 8 | EDID byte at edid_idx |
| tgt_selected | output | 1 | EDID target selected |
| tgt_available | output | 1 | EDID data available |
| tgt_port | output | 3 | Port recorded at selection |

## Verification
The assertions assume that reset is held from time zero for at least one edge, and that bus_addr and bus_wdata are stable at the sampling edge of a write. They also assume that edid_byte answers edid_idx within the same cycle, and that src_port and src_dp_sink hold steady while a request is processed. The stimulus changes every input on the falling edge. It keeps the EDID model purely combinational. It issues at most one register write per clock, with an idle cycle between accesses. As a result, no request ever overlaps another.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;
    localparam int REG_W        = 32;
    localparam int OFS_W        = 8;
    localparam logic [OFS_W-1:0] OFS_CTL    = 8'h10;
    localparam logic [OFS_W-1:0] OFS_DATA0  = 8'h14;
    localparam int CTL_BUSY_BIT = 31;
    localparam int CTL_DONE_BIT = 30;
    localparam int CTL_LEN_LSB  = 20;
    localparam int CTL_LEN_W    = 5;
    localparam logic [7:0]  I2C_ACK    = 8'h00;
    localparam logic [15:0] EDID_TGT   = 16'h0050;
    localparam logic [7:0]  NO_DATA    = 8'hFF;
    localparam logic [7:0]  PAST_END   = 8'h00;
    localparam logic [CTL_LEN_W-1:0] LEN_ADDR_ONLY = 5'd3;
    localparam logic [CTL_LEN_W-1:0] LEN_READ_ONE  = 5'd4;

    typedef enum logic [2:0] {
        K_IDLE, K_STOP, K_RESET, K_SELECT, K_ADDR_OTHER, K_WRITE, K_READ, K_BAD_READ
    } req_kind_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  op_low;
        logic [15:0] addr;
        logic [7:0]  pad;
    } aux_hdr_t;

    function automatic logic hdr_is_read(aux_hdr_t h);
        return h.op[0];
    endfunction

    function automatic logic hdr_mot(aux_hdr_t h);
        return h.op[2];
    endfunction
endpackage

// File: rtl/aux_edid_decode.sv
module aux_edid_decode
    import aux_edid_pkg::*;
(
    input  logic [REG_W-1:0]     ctl_wdata,
    input  aux_hdr_t             hdr,
    output req_kind_e            kind,
    output logic [CTL_LEN_W-1:0] reply_size
);
    logic [CTL_LEN_W-1:0] len;

    always_comb begin
        len        = ctl_wdata[CTL_LEN_LSB +: CTL_LEN_W];
        reply_size = hdr_is_read(hdr) ? CTL_LEN_W'(2) : CTL_LEN_W'(1);
        if (!ctl_wdata[CTL_BUSY_BIT])
            kind = K_IDLE;
        else if (len == LEN_ADDR_ONLY) begin
            if (!hdr_mot(hdr))              kind = K_STOP;
            else if (hdr.addr == '0)        kind = K_RESET;
            else if (hdr.addr == EDID_TGT)  kind = K_SELECT;
            else                            kind = K_ADDR_OTHER;
        end
        else if (!hdr_is_read(hdr))         kind = K_WRITE;
        else if (len == LEN_READ_ONE)       kind = K_READ;
        else                                kind = K_BAD_READ;
    end
endmodule

// File: rtl/aux_edid_track.sv
module aux_edid_track
    import aux_edid_pkg::*;
#(
    parameter int EDID_BYTES = 128,
    parameter int PORT_W     = 3,
    localparam int PTR_W     = $clog2(EDID_BYTES + 1),
    localparam int IDX_W     = $clog2(EDID_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  req_kind_e         kind,
    input  logic [PORT_W-1:0] port_in,
    input  logic              dp_in,
    input  logic [7:0]        edid_byte,
    output logic [IDX_W-1:0]  edid_idx,
    output logic [7:0]        reply_byte,
    output logic              sel_q,
    output logic              avail_q,
    output logic [PORT_W-1:0] port_q
);
    logic [PTR_W-1:0] ptr_q;
    logic             at_end;

    assign at_end     = (ptr_q >= PTR_W'(EDID_BYTES));
    assign edid_idx   = ptr_q[IDX_W-1:0];
    assign reply_byte = !(sel_q && avail_q) ? NO_DATA : (at_end ? PAST_END : edid_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            avail_q <= 1'b0;
            port_q  <= '0;
            ptr_q   <= '0;
        end
        else if (go) begin
            case (kind)
                K_STOP, K_RESET: begin
                    sel_q   <= 1'b0;
                    avail_q <= 1'b0;
                    port_q  <= '0;
                    ptr_q   <= '0;
                end
                K_SELECT: begin
                    sel_q   <= 1'b1;
                    avail_q <= dp_in;
                    port_q  <= port_in;
                end
                K_READ: if (sel_q && avail_q && !at_end) ptr_q <= ptr_q + 1'b1;
                default: ;
            endcase
        end
    end

    assert_ptr_bound_R11: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_W'(EDID_BYTES));
    assert_avail_needs_sel_R5: assert property (@(posedge clk) disable iff (rst)
        avail_q |-> sel_q);
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (ptr_q == $past(ptr_q)) || (ptr_q == $past(ptr_q) + 1'b1) || (ptr_q == '0));
endmodule

// File: rtl/aux_edid_regs.sv
module aux_edid_regs
    import aux_edid_pkg::*;
#(
    parameter int NDATA = 5,
    localparam int DIDX_W = $clog2(NDATA)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        host_we,
    input  logic [DIDX_W-1:0]           host_idx,
    input  logic [REG_W-1:0]            host_wdata,
    input  logic                        ctl_we,
    input  logic [REG_W-1:0]            ctl_val,
    input  logic                        d1_we,
    input  logic [REG_W-1:0]            d1_val,
    output logic [REG_W-1:0]            ctl_q,
    output logic [NDATA-1:0][REG_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_val;
    end

    for (genvar i = 0; i < NDATA; i++) begin : g_data
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)                              data_q[i] <= '0;
                else if (d1_we)                       data_q[i] <= d1_val;
                else if (host_we && host_idx == DIDX_W'(i)) data_q[i] <= host_wdata;
            end
        end
        else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst)                              data_q[i] <= '0;
                else if (host_we && host_idx == DIDX_W'(i)) data_q[i] <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int NDATA      = 5,
    parameter int EDID_BYTES = 128,
    parameter int PORT_W     = 3,
    localparam int DIDX_W    = $clog2(NDATA),
    localparam int IDX_W     = $clog2(EDID_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PORT_W-1:0] src_port,
    input  logic              src_dp_sink,
    output logic [IDX_W-1:0]  edid_idx,
    input  logic [7:0]        edid_byte,
    output logic              tgt_selected,
    output logic              tgt_available,
    output logic [PORT_W-1:0] tgt_port
);
    localparam logic [OFS_W-1:0] DATA_LAST = OFS_DATA0 + OFS_W'(4 * (NDATA - 1));

    logic [OFS_W-1:0]            rel;
    logic                        hit_ctl, hit_data;
    logic [DIDX_W-1:0]           didx;
    logic [REG_W-1:0]            ctl_q;
    logic [NDATA-1:0][REG_W-1:0] data_q;
    req_kind_e                   kind;
    logic [CTL_LEN_W-1:0]        reply_size;
    logic                        send;
    logic [7:0]                  reply_byte;
    logic [REG_W-1:0]            ctl_val, d1_val;

    assign rel      = bus_addr - OFS_DATA0;
    assign didx     = rel[2 +: DIDX_W];
    assign hit_ctl  = (bus_addr == OFS_CTL);
    assign hit_data = (bus_addr >= OFS_DATA0) && (bus_addr <= DATA_LAST) && (bus_addr[1:0] == 2'b00);
    assign send     = bus_wr && hit_ctl && (kind != K_IDLE);

    always_comb begin
        ctl_val = '0;
        ctl_val[CTL_DONE_BIT] = 1'b1;
        ctl_val[CTL_LEN_LSB +: CTL_LEN_W] = reply_size;
        d1_val  = {I2C_ACK, (kind == K_READ) ? reply_byte : 8'h00, 16'h0000};
    end

    aux_edid_decode u_decode (
        .ctl_wdata  (bus_wdata),
        .hdr        (aux_hdr_t'(data_q[0])),
        .kind       (kind),
        .reply_size (reply_size)
    );

    aux_edid_track #(.EDID_BYTES(EDID_BYTES), .PORT_W(PORT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .go         (send),
        .kind       (kind),
        .port_in    (src_port),
        .dp_in      (src_dp_sink),
        .edid_byte  (edid_byte),
        .edid_idx   (edid_idx),
        .reply_byte (reply_byte),
        .sel_q      (tgt_selected),
        .avail_q    (tgt_available),
        .port_q     (tgt_port)
    );

    aux_edid_regs #(.NDATA(NDATA)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (bus_wr && hit_data),
        .host_idx   (didx),
        .host_wdata (bus_wdata),
        .ctl_we     (send),
        .ctl_val    (ctl_val),
        .d1_we      (send && (kind != K_BAD_READ)),
        .d1_val     (d1_val),
        .ctl_q      (ctl_q),
        .data_q     (data_q)
    );

    always_comb begin
        if (hit_ctl)       bus_rdata = ctl_q;
        else if (hit_data) bus_rdata = data_q[didx];
        else               bus_rdata = '0;
    end

    assert_done_set_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_ctl && bus_wdata[CTL_BUSY_BIT]) |=> ctl_q[CTL_DONE_BIT]);
    assert_idle_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_ctl && !bus_wdata[CTL_BUSY_BIT]) |=> ($stable(ctl_q) && $stable(data_q[0])));
    assert_ack_code_R12: assert property (@(posedge clk) disable iff (rst)
        (send && kind != K_BAD_READ) |=> (data_q[0][31:24] == I2C_ACK));
    assert_bad_read_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (send && kind == K_BAD_READ) |=> $stable(data_q[0]));
endmodule

// File: tb/aux_edid_responder_bench.sv
`timescale 1ns/1ps
module aux_edid_responder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  src_port = 3'd0;
    logic        src_dp_sink = 1'b0;
    logic [6:0]  edid_idx;
    logic [7:0]  edid_byte;
    logic        tgt_selected, tgt_available;
    logic [2:0]  tgt_port;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] model_byte(int i);
        return 8'((i * 3) + 8'h11);
    endfunction
    assign edid_byte = model_byte(int'(edid_idx));

    aux_edid_responder u_aux_edid_responder (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_port(src_port),
        .src_dp_sink(src_dp_sink), .edid_idx(edid_idx), .edid_byte(edid_byte),
        .tgt_selected(tgt_selected), .tgt_available(tgt_available), .tgt_port(tgt_port)
    );

    // monitor: pops the expected item once the read address has settled
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            #1;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, e);
        end
    endtask

    task automatic request(input logic [31:0] hdr, input int len);
        bus_write(8'h14, hdr);
        bus_write(8'h10, 32'h8000_0000 | (32'(len) << 20));
    endtask

    function automatic logic [31:0] rd_reply(logic [7:0] b);
        return {8'h00, b, 16'h0000};
    endfunction

    initial begin
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(8'h10, 32'h0, "R1 ctl after reset");
        expect_rd(8'h14, 32'h0, "R1 data1 after reset");
        @(negedge clk);
        check_val("R1 selected after reset", 32'(tgt_selected), 0);

        // R2 data storage and unrecognised offsets
        bus_write(8'h18, 32'hA5A5_0001);
        bus_write(8'h24, 32'h1234_5678);
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_write(8'h15, 32'hEEEE_EEEE);
        expect_rd(8'h18, 32'hA5A5_0001, "R2 data2 readback");
        expect_rd(8'h24, 32'h1234_5678, "R2 data5 readback");
        expect_rd(8'h28, 32'h0, "R2 unknown offset reads zero");
        expect_rd(8'h14, 32'h0, "R2 misaligned write ignored");

        // R3 control write without busy
        bus_write(8'h14, 32'h5000_5000);
        bus_write(8'h10, 32'h0030_0000);
        expect_rd(8'h10, 32'h0, "R3 ctl unchanged");
        expect_rd(8'h14, 32'h5000_5000, "R3 data1 unchanged");
        @(negedge clk);
        check_val("R3 not selected", 32'(tgt_selected), 0);

        // R5/R4 select via write-flavoured address-only start, DP sink present
        src_port = 3'd5; src_dp_sink = 1'b1;
        request(32'h4000_5000, 3);
        expect_rd(8'h10, 32'h4010_0000, "R4 ctl size 1 for write");
        expect_rd(8'h14, 32'h0, "R12 ack on address-only");
        @(negedge clk);
        check_val("R5 selected", 32'(tgt_selected), 1);
        check_val("R5 available", 32'(tgt_available), 1);
        check_val("R5 port", 32'(tgt_port), 5);
        src_port = 3'd0;

        // R6 reads
        for (int i = 0; i < 3; i++) begin
            request(32'h1000_5000, 4);
            expect_rd(8'h14, rd_reply(model_byte(i)), "R6 read byte");
        end
        expect_rd(8'h10, 32'h4020_0000, "R4 ctl size 2 for read");

        // R8 bad read length
        request(32'h1000_5000, 5);
        expect_rd(8'h14, 32'h1000_5000, "R8 data1 kept");
        expect_rd(8'h10, 32'h4020_0000, "R8 ctl still completed");

        // R9 write of other length: acked, pointer untouched
        request(32'h0000_5000, 5);
        expect_rd(8'h14, 32'h0, "R9 write acked");
        request(32'h1000_5000, 4);
        expect_rd(8'h14, rd_reply(model_byte(3)), "R9 pointer unchanged by write");

        // R10 stop, then R7 unselected read
        request(32'h1000_5000, 3);
        @(negedge clk);
        check_val("R10 stop clears selection", 32'(tgt_selected), 0);
        request(32'h1000_5000, 4);
        expect_rd(8'h14, rd_reply(8'hFF), "R7 read while unselected");

        // R5/R7 select with no DP sink
        src_dp_sink = 1'b0;
        request(32'h5000_5000, 3);
        @(negedge clk);
        check_val("R5 selected without sink", 32'(tgt_selected), 1);
        check_val("R5 not available without sink", 32'(tgt_available), 0);
        request(32'h1000_5000, 4);
        expect_rd(8'h14, rd_reply(8'hFF), "R7 read while unavailable");

        // R10 MOT with address 0
        request(32'h5000_0000, 3);
        @(negedge clk);
        check_val("R10 address zero clears selection", 32'(tgt_selected), 0);

        // R11 full walk and saturation; pointer was reset by R10
        src_dp_sink = 1'b1;
        request(32'h5000_5000, 3);
        for (int i = 0; i < 128; i++) begin
            request(32'h1000_5000, 4);
            expect_rd(8'h14, rd_reply(model_byte(i)), "R6 walk byte");
        end
        request(32'h1000_5000, 4);
        expect_rd(8'h14, rd_reply(8'h00), "R11 first read past end");
        request(32'h1000_5000, 4);
        expect_rd(8'h14, rd_reply(8'h00), "R11 second read past end");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule